// File: doc/BRIEF.md
# Conversion Result Readout Port with End-of-Conversion Interrupt

This block sits between a successive-approximation sequencer and a host microprocessor bus. When the sequencer pulses its transfer strobe, the block captures the 10-bit result, starts a fixed-length one-shot and raises the end-of-conversion interrupt. The interrupt output is active low. The host reads the result with an active-low chip-select and an active-low read strobe. While both are low, the block enables its output drivers and clears the interrupt. A low chip-select together with a low write strobe starts a new conversion elsewhere in the converter, and here it also clears the interrupt.

A mode input selects the bus layout. In wide mode every read returns all 10 bits, right-aligned on a 16-bit bus. In narrow mode the result comes out left-justified on the low 8 bits over two reads: the high byte first, then the two least significant bits at the top of the second byte with zeros below them. A byte pointer alternates between the two bytes at the end of each completed read. Every transfer returns it to the high byte.

The one-shot sets the interrupt flag and overrides any clear while it runs. A host that holds its read enabled all the time therefore still sees a low interrupt pulse of exactly the one-shot length at each end of conversion.

Top module: `eoc_readout`

## Requirements
- R1: After reset, intr_no is 1, data_oe_o is 0, data_o is 0, the held result is 0 and the byte pointer selects the high byte.
- R2: data_oe_o is 1 exactly while cs_ni and rd_ni are both 0, and data_o is all zeros whenever data_oe_o is 0.
- R3: In wide mode (wide_i = 1) an enabled read gives data_o[9:0] = result and data_o[15:10] = 0.
- R4: In narrow mode (wide_i = 0), a read with the pointer on the high byte gives data_o[7:0] = result[9:2] and data_o[15:8] = 0.
- R5: In narrow mode, a read with the pointer on the low byte gives data_o[7] = result[1], data_o[6] = result[0] and all other bits 0.
- R6: In narrow mode the pointer toggles in the cycle after each completed read, which is the cycle in which cs_ni or rd_ni returns high. A third read after a transfer returns the high byte again.
- R7: A cycle with xfer_i = 1 latches result_i and returns the pointer to the high byte. result_i has no effect in any other cycle.
- R8: intr_no is 0 in the cycle after a cycle with xfer_i = 1.
- R9: A read (cs_ni = 0, rd_ni = 0) made after the one-shot has expired sets intr_no to 1 in the next cycle. With no read and no start, intr_no stays 0.
- R10: A start (cs_ni = 0, wr_ni = 0) made after the one-shot has expired sets intr_no to 1 in the next cycle.
- R11: With a clear request held all the time, each transfer drives intr_no to 0 for exactly PULSE_CYC cycles.
- R12: The default PULSE_CYC (40) at a 100 MHz clock gives an interrupt pulse of about 400 ns, within 360 to 440 ns.
- R13: A read strobe with cs_ni = 1 does not enable the drivers and does not advance the byte pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_i | input | 1 | Result transfer strobe from the sequencer, one cycle |
| result_i | input | 10 | Conversion result from the sequencer |
| wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus with two reads |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write (start) strobe, active low |
| data_o | output | 16 | Read data, zero when the drivers are off |
| data_oe_o | output | 1 | Output driver enable for the tri-state pads |
| intr_no | output | 1 | End-of-conversion interrupt, active low |

## Verification
The bench checks the byte order across three narrow reads. A pointer that never advances returns the high byte twice, and one that does not wrap returns the low byte on the third read. It moves the pointer onto the low byte and then issues a transfer, so a missing pointer reset shows up as a low byte on the next read. It holds the read enabled through a whole end of conversion and counts how long the interrupt stays low. A clear that wins over the one-shot gives a pulse that is too short or missing, and an off-by-one counter gives a length other than PULSE_CYC. A read strobe without chip select is also tried; a decode that ignores chip select would enable the drivers or skip a byte.

// File: rtl/eoc_readout_pkg.sv
package eoc_readout_pkg;
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/eoc_pulse_gen.sv
module eoc_pulse_gen #(
  parameter int PULSE_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o
);
  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R11
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R11
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == LOAD));
endmodule

// File: rtl/eoc_irq_flag.sv
module eoc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates: one-shot overrides a held clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/eoc_byte_mux.sv
module eoc_byte_mux
  import eoc_readout_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic             rd_done_i,
  input  logic             wide_i,
  input  logic             oe_i,
  input  logic [RES_W-1:0] res_i,
  output logic [BUS_W-1:0] data_o
);
  localparam int LO_BITS = RES_W - BYTE_W;
  localparam int LO_PAD  = BYTE_W - LO_BITS;

  byte_sel_e  sel_q;
  logic [BYTE_W-1:0] hi_byte, lo_byte, nar_byte;
  logic [BUS_W-1:0]  bus_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sel_q <= SEL_HI;
    else if (xfer_i || wide_i)      sel_q <= SEL_HI;
    else if (rd_done_i)             sel_q <= (sel_q == SEL_HI) ? SEL_LO : SEL_HI;
  end

  // left-justified split: upper bits first, remainder padded with zeros
  assign hi_byte  = res_i[RES_W-1 -: BYTE_W];
  assign lo_byte  = {res_i[LO_BITS-1:0], {LO_PAD{1'b0}}};
  assign nar_byte = (sel_q == SEL_HI) ? hi_byte : lo_byte;

  always_comb begin
    if (wide_i) bus_val = BUS_W'(res_i);
    else        bus_val = BUS_W'(nar_byte);
  end

  assign data_o = oe_i ? bus_val : '0;

  // R6
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && !xfer_i && !wide_i) |=> (sel_q != $past(sel_q)));

  // R7
  ptr_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (sel_q == SEL_HI));

  // R5
  lo_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !wide_i && sel_q == SEL_LO) |-> (data_o[LO_PAD-1:0] == '0));
endmodule

// File: rtl/eoc_readout.sv
module eoc_readout #(
  parameter int RES_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int BUS_W     = 16,
  parameter int PULSE_CYC = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             wide_i,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             intr_no
);
  logic [RES_W-1:0] res_q;
  logic rd_act, rd_act_q, rd_done, start_req;
  logic pulse_busy, irq_flag;

  assign rd_act    = !cs_ni && !rd_ni;
  assign start_req = !cs_ni && !wr_ni;
  assign rd_done   = rd_act_q && !rd_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q    <= '0;
      rd_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (xfer_i) res_q <= result_i;
    end
  end

  eoc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (xfer_i),
    .busy_o (pulse_busy)
  );

  eoc_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (xfer_i || pulse_busy),
    .clr_i  (rd_act || start_req),
    .flag_o (irq_flag)
  );

  eoc_byte_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W), .BUS_W(BUS_W)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (xfer_i),
    .rd_done_i (rd_done),
    .wide_i    (wide_i),
    .oe_i      (data_oe_o),
    .res_i     (res_q),
    .data_o    (data_o)
  );

  assign data_oe_o = rd_act;
  assign intr_no   = !irq_flag;

  // R7
  latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (res_q == $past(result_i)));

  // R7
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(res_q));

  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> !intr_no);

  // R3
  wide_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && wide_i) |-> (data_o[BUS_W-1:RES_W] == '0));
endmodule

// File: tb/sim_eoc_readout.sv
module sim_eoc_readout;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_i = 1'b0;
  logic [9:0]  result_i = '0;
  logic        wide_i = 1'b1;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [15:0] data_o;
  logic        data_oe_o, intr_no;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam int PULSE = 40;
  localparam int PERIOD_NS = 10;

  always #5 clk = ~clk;

  eoc_readout u0 (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_i(xfer_i), .result_i(result_i),
    .wide_i(wide_i), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .data_o(data_o), .data_oe_o(data_oe_o), .intr_no(intr_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare on each rising driver enable
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (data_oe_o && !prev_oe && exp_q.size() > 0) begin
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(data_o === e, t, data_o, e);
    end
    prev_oe <= data_oe_o;
  end

  task automatic xfer(input logic [9:0] v);
    @(posedge clk); #1 xfer_i = 1'b1; result_i = v;
    @(posedge clk); #1 xfer_i = 1'b0; result_i = ~v;  // R7: ignored outside xfer
  endtask

  task automatic do_read(input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rd_ni = 1'b1; cs_ni = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(intr_no === 1'b1, "R1 intr", intr_no, 1);
    chk(data_oe_o === 1'b0, "R1 oe", data_oe_o, 0);
    chk(data_o === 16'h0, "R1 data", data_o, 0);
    #1 rst_ni = 1'b1;
    do_read(16'h0000, "R1 result after reset");
    // R6 (reset pointer): narrow first read is high byte of 0
    wide_i = 1'b0;
    do_read(16'h0000, "R1 pointer high");
    wide_i = 1'b1;

    // wide mode
    xfer(10'h2B7);
    @(negedge clk);
    chk(intr_no === 1'b0, "R8 intr low after xfer", intr_no, 0);
    idle(PULSE + 5);
    @(negedge clk);
    chk(intr_no === 1'b0, "R9 intr held without clear", intr_no, 0);
    do_read(16'h02B7, "R3 wide read");
    @(negedge clk);
    chk(intr_no === 1'b1, "R9 intr cleared by read", intr_no, 1);

    // narrow mode: 0x3C5 -> hi 0xF1, lo 0x40
    wide_i = 1'b0;
    xfer(10'h3C5);
    idle(PULSE + 5);
    do_read(16'h00F1, "R4 narrow high byte");
    do_read(16'h0040, "R5 narrow low byte");
    do_read(16'h00F1, "R6 third read wraps to high");

    // pointer now on low byte; transfer must rewind it. 0x155 -> 0x55 / 0x40
    xfer(10'h155);
    idle(PULSE + 5);
    do_read(16'h0055, "R7 pointer rewound by xfer");
    do_read(16'h0040, "R7 result_i ignored after xfer");

    // R13: strobe without chip select
    #1 rd_ni = 1'b0;
    @(negedge clk);
    chk(data_oe_o === 1'b0, "R13 no enable without cs", data_oe_o, 0);
    chk(data_o === 16'h0, "R2 data zero when disabled", data_o, 0);
    @(posedge clk); #1 rd_ni = 1'b1;
    idle(2);
    do_read(16'h0055, "R13 pointer not advanced");

    // all-ones boundary
    xfer(10'h3FF);
    idle(PULSE + 5);
    do_read(16'h00FF, "R4 all ones high");
    do_read(16'h00C0, "R5 all ones low");

    // R10: start clears
    xfer(10'h0AA);
    idle(PULSE + 5);
    @(negedge clk);
    chk(intr_no === 1'b0, "R10 intr low before start", intr_no, 0);
    @(posedge clk); #1 cs_ni = 1'b0; wr_ni = 1'b0;
    @(posedge clk); #1 cs_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk);
    chk(intr_no === 1'b1, "R10 intr cleared by start", intr_no, 1);

    // R11/R12: continuous read, pulse still seen
    wide_i = 1'b1;
    @(posedge clk); #1 cs_ni = 1'b0; rd_ni = 1'b0;
    idle(3);
    @(negedge clk);
    chk(data_oe_o === 1'b1, "R2 enable while held", data_oe_o, 1);
    chk(intr_no === 1'b1, "R11 intr high before xfer", intr_no, 1);
    xfer(10'h1A5);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (intr_no === 1'b0) n++;
      else break;
    end
    chk(n == PULSE, "R11 pulse length cycles", n, PULSE);
    chk(n * PERIOD_NS >= 360 && n * PERIOD_NS <= 440, "R12 pulse near 400 ns", n * PERIOD_NS, 400);
    chk(data_o === 16'h01A5, "R3 wide data during held read", data_o, 16'h01A5);
    @(posedge clk); #1 cs_ni = 1'b1; rd_ni = 1'b1;
    @(negedge clk);
    chk(data_oe_o === 1'b0, "R2 disable on release", data_oe_o, 0);

    idle(3);
    chk(exp_q.size() == 0, "R2 all reads seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule